// File: doc/BRIEF.md
# SDRAM Row Timing Guard

This block sits on the command path between a simple SDRAM command scheduler and the SDRAM command bus for a single bank. Software writes a small configuration word holding a CAS latency select bit, an encoded row-cycle minimum and an encoded row-active minimum. The block turns the two encoded fields into clock counts and uses them to hold off activate and precharge requests until enough clocks have passed since the most recent activate.

The scheduler offers activate and precharge requests through valid/ready handshakes. A granted request is driven onto the command outputs on the next clock for a single cycle. Whenever the CAS latency bit in the register differs from the latency last programmed into the SDRAM, the block inserts a mode-register-set command carrying the new latency. It waits until the bank is precharged to do so and keeps activates back for a short settling window afterwards.

Top module: `sdram_row_guard`

## Requirements
- R1: After reset the register holds latency-select 1, row-cycle code 011 and row-active code 11; `cas_latency` reads 3, `config_error` is 0, no command is driven, `pre_ready` is 0 and `act_ready` is 1.
- R2: `cfg_wdata` bit 5 selects the CAS latency (0 gives 2 clocks, 1 gives 3 clocks). `cas_latency` shows the selected value from the clock after the write.
- R3: When a write changes bit 5 in either direction, exactly one mode-register-set is issued (`cmd_op` = 11) with `cmd_cl` equal to the new latency (2 or 3). `cmd_cl` is 0 on every other command.
- R4: A write that leaves bit 5 equal to the latency already programmed issues no mode-register-set. This also covers a flip and a flip back that both happen before the command could go out.
- R5: A mode-register-set goes out only while the bank is precharged. If the bank is open, it waits until the precharge has been granted.
- R6: While a mode-register-set is owed, `act_ready` stays low. It also stays low for the 2 clocks after the clock in which the mode-register-set is granted, so at least 2 clocks separate the mode-register-set output from the next activate output.
- R7: `cfg_wdata` bits 4:2 give the minimum clocks between activates: 110→6, 111→7, 000→8, 001→9, 010→10, 011→11. A second activate cannot be granted fewer than that many clocks after the previous grant.
- R8: Row-cycle codes 100 and 101 are reserved. They act as 11 clocks and set `config_error`, which stays set until reset.
- R9: `cfg_wdata` bits 1:0 give the minimum clocks from activate to precharge: 00→4, 01→5, 10→6, 11→7. A precharge cannot be granted fewer than that many clocks after the activate grant.
- R10: An activate is granted only when the bank is precharged, and a precharge only when the bank is open. The two ready signals are never high together.
- R11: A request is granted in the clock where its valid and ready are both high. The command appears on `cmd_valid`/`cmd_op` (01 activate, 10 precharge, 11 mode-register-set, 00 none) in the next clock for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Bit 5 latency select, bits 4:2 row-cycle code, bits 1:0 row-active code |
| act_valid | input | 1 | Activate request from scheduler |
| act_ready | output | 1 | Activate may be granted this clock |
| pre_valid | input | 1 | Precharge request from scheduler |
| pre_ready | output | 1 | Precharge may be granted this clock |
| cmd_valid | output | 1 | Command present on the bus |
| cmd_op | output | 2 | Command code |
| cmd_cl | output | 2 | Latency carried by a mode-register-set, else 0 |
| cas_latency | output | 2 | Currently selected CAS latency |
| config_error | output | 1 | Sticky reserved-code flag |

## Verification
Ready signals are combinational from registered state, so they respond in the same clock as a grant-free state. A write reaches `cas_latency`, `config_error` and the timing limits one clock later, and a grant shows on the command outputs one clock later. A mode-register-set decision made in clock d puts the command out at d+1, and the earliest activate output is at d+4. The bench drives inputs just after the falling edge. In that same half cycle it compares every output with a behavioural model that advances once per clock, so each result is checked in the exact clock it is due.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_ACT  = 2'b01,
      OP_PRE  = 2'b10,
      OP_MRS  = 2'b11
   } guard_op_e;

   typedef struct packed {
      logic       cl3;
      logic [2:0] rc_code;
      logic [1:0] ras_code;
   } guard_cfg_t;

   localparam int unsigned RC_SAFE_CLKS = 11;
   localparam int unsigned RC_MAX_CLKS  = 11;

   function automatic logic rc_is_reserved(input logic [2:0] code);
      return (code == 3'b100) || (code == 3'b101);
   endfunction

   function automatic int unsigned rc_clocks(input logic [2:0] code);
      int unsigned n;
      case (code)
         3'b110:  n = 6;
         3'b111:  n = 7;
         3'b000:  n = 8;
         3'b001:  n = 9;
         3'b010:  n = 10;
         3'b011:  n = 11;
         default: n = RC_SAFE_CLKS;
      endcase
      return n;
   endfunction

   function automatic int unsigned ras_clocks(input logic [1:0] code);
      return 32'd4 + {30'd0, code};
   endfunction

endpackage

// File: rtl/sdram_guard_cfg.sv
module sdram_guard_cfg
   import sdram_guard_pkg::*;
#(
   parameter int unsigned CNT_W           = 4,
   parameter bit          DECODE_AT_WRITE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  guard_cfg_t       wdata,
   output logic             cl3,
   output logic [CNT_W-1:0] rc_cnt,
   output logic [CNT_W-1:0] ras_cnt,
   output logic             cfg_err
);

   localparam logic [2:0] RST_RC  = 3'b011;
   localparam logic [1:0] RST_RAS = 2'b11;

   logic cl3_q;
   logic err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl3_q <= 1'b1;
         err_q <= 1'b0;
      end else if (we) begin
         cl3_q <= wdata.cl3;
         if (rc_is_reserved(wdata.rc_code)) err_q <= 1'b1;
      end
   end

   generate
      if (DECODE_AT_WRITE) begin : g_dec_write
         logic [CNT_W-1:0] rc_q, ras_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rc_q  <= CNT_W'(rc_clocks(RST_RC));
               ras_q <= CNT_W'(ras_clocks(RST_RAS));
            end else if (we) begin
               rc_q  <= CNT_W'(rc_clocks(wdata.rc_code));
               ras_q <= CNT_W'(ras_clocks(wdata.ras_code));
            end
         end
         assign rc_cnt  = rc_q;
         assign ras_cnt = ras_q;
      end else begin : g_dec_read
         logic [2:0] rc_code_q;
         logic [1:0] ras_code_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rc_code_q  <= RST_RC;
               ras_code_q <= RST_RAS;
            end else if (we) begin
               rc_code_q  <= wdata.rc_code;
               ras_code_q <= wdata.ras_code;
            end
         end
         assign rc_cnt  = CNT_W'(rc_clocks(rc_code_q));
         assign ras_cnt = CNT_W'(ras_clocks(ras_code_q));
      end
   endgenerate

   assign cl3     = cl3_q;
   assign cfg_err = err_q;

endmodule

// File: rtl/sdram_guard_timer.sv
module sdram_guard_timer #(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned MRS_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire,
   input  logic             mrs_fire,
   output logic [CNT_W-1:0] since_act,
   output logic             hold_busy
);

   localparam int unsigned HW = (MRS_GAP < 2) ? 1 : $clog2(MRS_GAP + 1);

   logic [CNT_W-1:0] since_q;
   logic [HW-1:0]    hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= '1;
      end else if (act_fire) begin
         since_q <= CNT_W'(1);
      end else if (since_q != '1) begin
         since_q <= since_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (mrs_fire) begin
         hold_q <= HW'(MRS_GAP);
      end else if (hold_q != '0) begin
         hold_q <= hold_q - HW'(1);
      end
   end

   assign since_act = since_q;
   assign hold_busy = (hold_q != '0);

endmodule

// File: rtl/sdram_guard_arb.sv
module sdram_guard_arb
   import sdram_guard_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cl3,
   input  logic [CNT_W-1:0] rc_cnt,
   input  logic [CNT_W-1:0] ras_cnt,
   input  logic [CNT_W-1:0] since_act,
   input  logic             hold_busy,
   input  logic             act_valid,
   input  logic             pre_valid,
   output logic             act_ready,
   output logic             pre_ready,
   output logic             act_fire,
   output logic             mrs_fire,
   output logic             cmd_valid,
   output logic [1:0]       cmd_op,
   output logic [1:0]       cmd_cl
);

   logic      open_q;
   logic      prog_cl3_q;
   logic      vld_q;
   guard_op_e op_q;
   logic [1:0] cl_q;
   logic      mrs_owed;
   logic      pre_fire;

   assign mrs_owed  = (cl3 != prog_cl3_q);
   assign mrs_fire  = mrs_owed && !open_q;
   assign act_ready = !mrs_owed && !hold_busy && !open_q && (since_act >= rc_cnt);
   assign pre_ready = open_q && (since_act >= ras_cnt);
   assign act_fire  = act_valid && act_ready;
   assign pre_fire  = pre_valid && pre_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q     <= 1'b0;
         prog_cl3_q <= 1'b1;
         vld_q      <= 1'b0;
         op_q       <= OP_NONE;
         cl_q       <= 2'd0;
      end else begin
         vld_q <= mrs_fire || act_fire || pre_fire;
         if (mrs_fire)      op_q <= OP_MRS;
         else if (act_fire) op_q <= OP_ACT;
         else if (pre_fire) op_q <= OP_PRE;
         else               op_q <= OP_NONE;
         cl_q <= mrs_fire ? (cl3 ? 2'd3 : 2'd2) : 2'd0;
         if (act_fire)      open_q <= 1'b1;
         else if (pre_fire) open_q <= 1'b0;
         if (mrs_fire) prog_cl3_q <= cl3;
      end
   end

   assign cmd_valid = vld_q;
   assign cmd_op    = op_q;
   assign cmd_cl    = cl_q;

endmodule

// File: rtl/sdram_row_guard.sv
module sdram_row_guard
   import sdram_guard_pkg::*;
#(
   parameter int unsigned CNT_W           = 4,
   parameter int unsigned MRS_GAP         = 2,
   parameter bit          DECODE_AT_WRITE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [5:0] cfg_wdata,
   input  logic       act_valid,
   output logic       act_ready,
   input  logic       pre_valid,
   output logic       pre_ready,
   output logic       cmd_valid,
   output logic [1:0] cmd_op,
   output logic [1:0] cmd_cl,
   output logic [1:0] cas_latency,
   output logic       config_error
);

   generate
      if ((2 ** CNT_W) - 1 < RC_MAX_CLKS) begin : g_bad_cnt_w
         $error("CNT_W too small for the largest row-cycle count");
      end
      if (MRS_GAP < 1) begin : g_bad_gap
         $error("MRS_GAP must be at least 1");
      end
   endgenerate

   logic             cl3;
   logic [CNT_W-1:0] rc_cnt, ras_cnt, since_act;
   logic             hold_busy, act_fire, mrs_fire;
   guard_cfg_t       wcfg;

   assign wcfg = guard_cfg_t'(cfg_wdata);

   sdram_guard_cfg #(.CNT_W(CNT_W), .DECODE_AT_WRITE(DECODE_AT_WRITE)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (wcfg),
      .cl3     (cl3),
      .rc_cnt  (rc_cnt),
      .ras_cnt (ras_cnt),
      .cfg_err (config_error)
   );

   sdram_guard_timer #(.CNT_W(CNT_W), .MRS_GAP(MRS_GAP)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_fire  (act_fire),
      .mrs_fire  (mrs_fire),
      .since_act (since_act),
      .hold_busy (hold_busy)
   );

   sdram_guard_arb #(.CNT_W(CNT_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cl3       (cl3),
      .rc_cnt    (rc_cnt),
      .ras_cnt   (ras_cnt),
      .since_act (since_act),
      .hold_busy (hold_busy),
      .act_valid (act_valid),
      .pre_valid (pre_valid),
      .act_ready (act_ready),
      .pre_ready (pre_ready),
      .act_fire  (act_fire),
      .mrs_fire  (mrs_fire),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_cl    (cmd_cl)
   );

   assign cas_latency = cl3 ? 2'd3 : 2'd2;

endmodule

// File: rtl/sdram_row_guard_chk.sv
module sdram_row_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [5:0] cfg_wdata,
   input logic       act_valid,
   input logic       act_ready,
   input logic       pre_valid,
   input logic       pre_ready,
   input logic       cmd_valid,
   input logic [1:0] cmd_op,
   input logic [1:0] cmd_cl,
   input logic [1:0] cas_latency,
   input logic       config_error
);

   assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_ready && pre_ready));

   assert_act_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && act_ready) |=> (cmd_valid && cmd_op == 2'b01));

   assert_pre_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_valid && pre_ready) |=> (cmd_valid && cmd_op == 2'b10));

   assert_op_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (cmd_op == 2'b00));

   assert_mrs_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b11) |-> !act_ready);

   assert_mrs_bank_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b11) |-> !pre_ready);

   assert_mrs_cl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b11) |-> (cmd_cl == 2'd2 || cmd_cl == 2'd3));

   assert_pre_after_act_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01) |-> !pre_ready);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |=> config_error);

endmodule

bind sdram_row_guard sdram_row_guard_chk u_chk (.*);

// File: tb/sdram_row_guard_bench.sv
`timescale 1ns/1ps
module sdram_row_guard_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_wdata = 6'd0;
   logic       act_valid = 1'b0;
   logic       pre_valid = 1'b0;
   logic       act_ready, pre_ready, cmd_valid, config_error;
   logic [1:0] cmd_op, cmd_cl, cas_latency;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // behavioural model state
   int m_cl = 1, m_prog = 1, m_rc = 11, m_ras = 7;
   int m_open = 0, m_since = 1000, m_hold = 0, m_err = 0;
   int m_vld = 0, m_op = 0, m_cmdcl = 0;

   always #2.5 clk = ~clk;

   sdram_row_guard u_sdram_row_guard (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .act_valid(act_valid), .act_ready(act_ready),
      .pre_valid(pre_valid), .pre_ready(pre_ready),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cl(cmd_cl),
      .cas_latency(cas_latency), .config_error(config_error)
   );

   function automatic int rc_of(input int code);
      case (code)
         6: return 6;  7: return 7;  0: return 8;
         1: return 9;  2: return 10; 3: return 11;
         default: return 11;
      endcase
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cycles);
      end
   endtask

   task automatic step();
      int exp_ar, exp_pr, mfire, ag, pg;
      exp_ar = (m_cl == m_prog && m_hold == 0 && !m_open && m_since >= m_rc) ? 1 : 0;
      exp_pr = (m_open && m_since >= m_ras) ? 1 : 0;
      chk("R6 R7 R10 act_ready", {31'd0, act_ready}, exp_ar);
      chk("R9 R10 pre_ready", {31'd0, pre_ready}, exp_pr);
      chk("R11 cmd_valid", {31'd0, cmd_valid}, m_vld);
      chk("R3 R4 R5 R11 cmd_op", {30'd0, cmd_op}, m_op);
      chk("R3 cmd_cl", {30'd0, cmd_cl}, m_cmdcl);
      chk("R2 cas_latency", {30'd0, cas_latency}, m_cl ? 3 : 2);
      chk("R8 config_error", {31'd0, config_error}, m_err);
      mfire = (m_cl != m_prog && !m_open) ? 1 : 0;
      ag = (act_valid && exp_ar) ? 1 : 0;
      pg = (pre_valid && exp_pr) ? 1 : 0;
      m_vld = mfire | ag | pg;
      m_op = mfire ? 3 : ag ? 1 : pg ? 2 : 0;
      m_cmdcl = mfire ? (m_cl ? 3 : 2) : 0;
      if (ag) m_since = 1; else if (m_since < 1000) m_since++;
      if (mfire) m_hold = 2; else if (m_hold > 0) m_hold--;
      if (ag) m_open = 1; else if (pg) m_open = 0;
      if (mfire) m_prog = m_cl;
      if (cfg_we) begin
         m_cl = cfg_wdata[5];
         m_rc = rc_of(cfg_wdata[4:2]);
         m_ras = 4 + cfg_wdata[1:0];
         if (cfg_wdata[4:2] == 3'b100 || cfg_wdata[4:2] == 3'b101) m_err = 1;
      end
      @(negedge clk); #1;
      cycles++;
   endtask

   task automatic run(input int n, input logic av, input logic pv);
      act_valid = av; pre_valid = pv;
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [5:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 reset cas_latency", {30'd0, cas_latency}, 3);
      chk("R1 reset config_error", {31'd0, config_error}, 0);
      chk("R1 reset cmd_valid", {31'd0, cmd_valid}, 0);
      chk("R1 reset act_ready", {31'd0, act_ready}, 1);
      chk("R1 reset pre_ready", {31'd0, pre_ready}, 0);
      run(60, 1'b1, 1'b1);                       // default timing
      for (int c = 0; c < 8; c++) begin          // every row-cycle code, R7 R8 R9
         wr({1'b1, c[2:0], c[1:0]});
         run(50, 1'b1, 1'b1);
      end
      run(20, 1'b0, 1'b1);                       // close bank
      wr(6'b0_110_00);                           // flip to 2 while idle, R3
      run(30, 1'b1, 1'b0);                       // R6, bank ends open
      wr(6'b1_110_00);                           // flip while open, R5
      run(12, 1'b1, 1'b0);
      run(30, 1'b1, 1'b1);
      wr(6'b1_111_01);                           // same latency, R4
      run(30, 1'b1, 1'b1);
      run(12, 1'b1, 1'b0);
      wr(6'b0_111_01);                           // flip and flip back while open, R4
      run(2, 1'b1, 1'b0);
      wr(6'b1_111_01);
      run(30, 1'b1, 1'b1);
      for (int i = 0; i < 3000; i++) begin       // mixed traffic
         act_valid = $urandom_range(0, 1);
         pre_valid = $urandom_range(0, 1);
         if ($urandom_range(0, 40) == 0) wr(6'($urandom_range(0, 63)));
         else step();
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule